// File: doc/BRIEF.md
# Keyed Peripheral Clock Gate and Divider

This block controls one peripheral clock through a small word-addressed register bus. Software first writes a fixed key value to the key register to open the other registers for writing. It then turns the gate on or off, picks a reference source and a division ratio, and commits the source and ratio with a trigger that clears itself. The block does no real clock switching. Each reference clock comes in as a one-cycle tick in the system clock domain, and the divided output leaves as a one-cycle enable pulse.

The gate has a software enable bit and a read-only running status that are kept apart. A select bit decides whether the gate request comes from the software enable bit or from a hardware request pin. The status bit copies that request after a fixed settle delay, and the output can pulse only while the status reads running. The divider and selector have a pending copy, which software writes, and an active copy, which drives the output. The active copy is loaded only when a trigger handshake completes.

Top module: `pclk_ctrl`

## Requirements
- R1: Word 0 is the key register. A write of 0x00A5A501 unlocks the block and a write of 0 locks it. A write of any other value leaves the lock state as it was. Reading word 0 returns the unlocked flag in bit 0.
- R2: While the block is locked, writes to every word other than word 0 are ignored. Reads of every word work whether the block is locked or unlocked. Reads of unused words return 0.
- R3: The gate register is word 1. Bit 0 is the software enable and bit 1 is the select bit, and both can be written. Bit 2 is the running status and can only be read, so writes to it have no effect.
- R4: When the select bit is 1, the gate request equals the software enable bit. When the select bit is 0, the gate request equals the `hw_gate_req` input.
- R5: The status bit equals the gate request delayed by exactly 4 clock cycles.
- R6: Word 2 holds the pending divider value in bits [3:0] and the pending selector in bits [9:8]. Word 4 is read-only and returns the active values in the same bit positions. The active values change only when a trigger completes.
- R7: Word 3 bit 0 is the trigger. A write of 1 while the trigger is idle makes it read 1. It reads 0 again 3 cycles after the write edge, and on that same edge the pending values are copied into the active values. A trigger write while the trigger is busy is ignored. A word-2 write that lands on the completion edge is not included in that commit.
- R8: The output `clk_en_out` rises in the cycle after every (active divider + 1)-th tick of `ref_tick[active selector]`. The tick count restarts from zero at every commit and is held at zero while the status is 0.
- R9: `clk_en_out` is 0 whenever the status was 0 in the cycle before.
- R10: After reset the block is locked. Every register field is 0, the trigger is idle, and the output is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| bus_addr | input | 3 | Word address |
| bus_wdata | input | 32 | Write data |
| bus_we | input | 1 | Write strobe |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| ref_tick | input | 4 | One tick per reference clock edge |
| hw_gate_req | input | 1 | Gate request used when the select bit is 0 |
| clk_en_out | output | 1 | Divided clock enable pulse |

## Verification
Two functions can fall in the same cycle: trigger completion, which loads the active settings, and a software write to the pending settings. The bench provokes this on purpose by placing a word-2 write exactly three edges after a trigger write. It then reads word 4 to confirm that the active values are the ones pending before that write, and reads word 2 to confirm that the new value is now pending. Random traffic provides many more such overlaps, as well as lock changes and gate changes that coincide with divider ticks. A cycle-level model in the bench, built from the requirements, judges every read and every output pulse.

// File: rtl/pclk_ctrl.sv
module pclk_ctrl #(
  parameter int          ADDR_W     = 3,
  parameter int          NUM_REFS   = 4,
  parameter int          DIV_W      = 4,
  parameter int          STATUS_LAT = 4,
  parameter int          TRIG_LAT   = 3,
  parameter logic [31:0] KEY        = 32'h00A5A501
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  input  logic              bus_we,
  output logic [31:0]       bus_rdata,
  input  logic [NUM_REFS-1:0] ref_tick,
  input  logic              hw_gate_req,
  output logic              clk_en_out
);
  localparam int SEL_W   = (NUM_REFS > 1) ? $clog2(NUM_REFS) : 1;
  localparam int SEL_POS = 8;
  localparam int TCNT_W  = $clog2(TRIG_LAT + 1);

  logic                  unlocked, sw_en, hw_sel, busy;
  logic [STATUS_LAT-1:0] st_pipe;
  logic [DIV_W-1:0]      pend_div, act_div, dcnt;
  logic [SEL_W-1:0]      pend_sel, act_sel;
  logic [TCNT_W-1:0]     tcnt;

  wire wr_ok    = bus_we && unlocked && (bus_addr != '0);
  wire commit   = busy && (tcnt == TCNT_W'(1));
  wire status   = st_pipe[STATUS_LAT-1];
  wire gate_req = hw_sel ? sw_en : hw_gate_req;
  wire sel_ok   = {1'b0, act_sel} < (SEL_W+1)'(NUM_REFS);
  wire sel_tick = sel_ok ? ref_tick[act_sel] : 1'b0;
  wire div_hit  = (dcnt == act_div);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      unlocked <= 1'b0;
      sw_en    <= 1'b0;
      hw_sel   <= 1'b0;
      st_pipe  <= '0;
      pend_div <= '0;
      pend_sel <= '0;
      act_div  <= '0;
      act_sel  <= '0;
      busy     <= 1'b0;
      tcnt     <= '0;
      dcnt     <= '0;
      clk_en_out <= 1'b0;
    end else begin
      if (bus_we && bus_addr == '0) begin
        if (bus_wdata == KEY)        unlocked <= 1'b1;
        else if (bus_wdata == 32'h0) unlocked <= 1'b0;
      end
      if (wr_ok && bus_addr == ADDR_W'(1)) begin
        sw_en  <= bus_wdata[0];
        hw_sel <= bus_wdata[1];
      end
      if (wr_ok && bus_addr == ADDR_W'(2)) begin
        pend_div <= bus_wdata[DIV_W-1:0];
        pend_sel <= bus_wdata[SEL_POS +: SEL_W];
      end
      st_pipe <= {st_pipe[STATUS_LAT-2:0], gate_req};
      if (busy) begin
        tcnt <= tcnt - TCNT_W'(1);
        if (commit) begin
          busy    <= 1'b0;
          act_div <= pend_div;
          act_sel <= pend_sel;
        end
      end else if (wr_ok && bus_addr == ADDR_W'(3) && bus_wdata[0]) begin
        busy <= 1'b1;
        tcnt <= TCNT_W'(TRIG_LAT);
      end
      if (commit || !status)  dcnt <= '0;
      else if (sel_tick)      dcnt <= div_hit ? '0 : dcnt + DIV_W'(1);
      clk_en_out <= status && sel_tick && div_hit;
    end
  end

  always_comb begin
    bus_rdata = '0;
    case (bus_addr)
      ADDR_W'(0): bus_rdata[0] = unlocked;
      ADDR_W'(1): bus_rdata[2:0] = {status, hw_sel, sw_en};
      ADDR_W'(2): begin
        bus_rdata[DIV_W-1:0]       = pend_div;
        bus_rdata[SEL_POS +: SEL_W] = pend_sel;
      end
      ADDR_W'(3): bus_rdata[0] = busy;
      ADDR_W'(4): begin
        bus_rdata[DIV_W-1:0]       = act_div;
        bus_rdata[SEL_POS +: SEL_W] = act_sel;
      end
      default: bus_rdata = '0;
    endcase
  end

  assert_key_opens_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && bus_addr == '0 && bus_wdata == KEY) |=> unlocked);

  assert_locked_ignore_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!unlocked && bus_we && bus_addr != '0) |=> $stable({sw_en, hw_sel, pend_div, pend_sel}));

  assert_active_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !$fell(busy) |-> ($stable(act_div) && $stable(act_sel)));

  assert_commit_copy_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> (act_div == $past(pend_div) && act_sel == $past(pend_sel)));

  assert_trig_busy_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |=> busy);

  assert_gate_low_R9: assert property (@(posedge clk) disable iff (!rst_n)
    clk_en_out |-> $past(status));
endmodule

// File: tb/tb_pclk_ctrl.sv
module tb_pclk_ctrl;
  localparam logic [31:0] KEY = 32'h00A5A501;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [2:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic        bus_we = 1'b0;
  logic [31:0] bus_rdata;
  logic [3:0]  ref_tick = '0;
  logic        hw_gate_req = 1'b0;
  logic        clk_en_out;

  int total = 0;
  int bad = 0;

  pclk_ctrl dut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_we(bus_we), .bus_rdata(bus_rdata), .ref_tick(ref_tick),
    .hw_gate_req(hw_gate_req), .clk_en_out(clk_en_out)
  );

  always #2 clk = ~clk;

  logic       m_unl, m_en, m_hsel, m_busy, m_out;
  logic [3:0] m_pipe, m_pdiv, m_adiv, m_dcnt;
  logic [1:0] m_psel, m_asel;
  int         m_tcnt;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_unl <= 0; m_en <= 0; m_hsel <= 0; m_busy <= 0; m_out <= 0;
      m_pipe <= 0; m_pdiv <= 0; m_adiv <= 0; m_dcnt <= 0;
      m_psel <= 0; m_asel <= 0; m_tcnt <= 0;
    end else begin
      automatic logic ok   = bus_we && m_unl && bus_addr != 0;
      automatic logic st   = m_pipe[3];
      automatic logic tk   = ref_tick[m_asel];
      automatic logic done = m_busy && m_tcnt == 1;
      if (bus_we && bus_addr == 0 && bus_wdata == KEY) m_unl <= 1;
      if (bus_we && bus_addr == 0 && bus_wdata == 0)   m_unl <= 0;
      if (ok && bus_addr == 1) begin m_en <= bus_wdata[0]; m_hsel <= bus_wdata[1]; end
      if (ok && bus_addr == 2) begin m_pdiv <= bus_wdata[3:0]; m_psel <= bus_wdata[9:8]; end
      m_pipe <= {m_pipe[2:0], m_hsel ? m_en : hw_gate_req};
      if (m_busy) begin
        m_tcnt <= m_tcnt - 1;
        if (done) begin m_busy <= 0; m_adiv <= m_pdiv; m_asel <= m_psel; end
      end else if (ok && bus_addr == 3 && bus_wdata[0]) begin
        m_busy <= 1; m_tcnt <= 3;
      end
      if (done || !st) m_dcnt <= 0;
      else if (tk) m_dcnt <= (m_dcnt == m_adiv) ? 4'd0 : m_dcnt + 4'd1;
      m_out <= st && tk && m_dcnt == m_adiv;
    end
  end

  function automatic logic [31:0] exp_read(input logic [2:0] a);
    case (a)
      3'd0: return {31'd0, m_unl};
      3'd1: return {29'd0, m_pipe[3], m_hsel, m_en};
      3'd2: return {22'd0, m_psel, 4'd0, m_pdiv};
      3'd3: return {31'd0, m_busy};
      3'd4: return {22'd0, m_asel, 4'd0, m_adiv};
      default: return 32'd0;
    endcase
  endfunction

  function automatic string tag_of(input logic [2:0] a);
    case (a)
      3'd0: return "R1";
      3'd1: return "R3";
      3'd2, 3'd4: return "R6";
      3'd3: return "R7";
      default: return "R2";
    endcase
  endfunction

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s got=%h exp=%h t=%0t", tag, got, exp, $time);
    end
  endtask

  task automatic drive(input logic we, input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    chk(tag_of(bus_addr), bus_rdata, exp_read(bus_addr));
    chk(m_pipe[3] ? "R8" : "R9", {31'd0, clk_en_out}, {31'd0, m_out});
    bus_we = we; bus_addr = a; bus_wdata = d;
  endtask

  task automatic rd_chk(input logic [2:0] a, input logic [31:0] exp, input string tag);
    drive(0, a, 0);
    #1 chk(tag, bus_rdata, exp);
  endtask

  initial begin
    #(4 * 150000);
    bad++; total++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    for (int a = 0; a < 5; a++) rd_chk(3'(a), 32'd0, "R10");
    chk("R10", {31'd0, clk_en_out}, 32'd0);

    drive(1, 1, 32'h3);
    rd_chk(1, 32'd0, "R2");
    drive(1, 0, 32'h1234);
    rd_chk(0, 32'd0, "R1");
    drive(1, 0, KEY);
    rd_chk(0, 32'd1, "R1");
    drive(1, 0, 32'h77);
    rd_chk(0, 32'd1, "R1");

    ref_tick = 4'b1111;
    drive(1, 1, 32'h7);
    rd_chk(1, 32'h3, "R5");
    rd_chk(1, 32'h3, "R5");
    rd_chk(1, 32'h3, "R5");
    rd_chk(1, 32'h3, "R5");
    rd_chk(1, 32'h7, "R5");

    drive(1, 2, 32'h0000_0102);
    rd_chk(4, 32'd0, "R6");
    drive(1, 3, 32'h1);
    drive(1, 3, 32'h1);
    drive(0, 3, 0);
    drive(1, 2, 32'h0000_0305);
    rd_chk(4, 32'h0000_0102, "R7");
    rd_chk(2, 32'h0000_0305, "R7");
    rd_chk(3, 32'd0, "R7");
    repeat (12) drive(0, 4, 0);

    drive(1, 1, 32'h2);
    hw_gate_req = 1'b1;
    repeat (6) drive(0, 1, 0);
    drive(1, 1, 32'h0);
    repeat (6) drive(0, 1, 0);
    rd_chk(1, 32'h4, "R4");

    for (int i = 0; i < 6000; i++) begin
      automatic int r = $urandom_range(0, 99);
      automatic logic [2:0] a = 3'($urandom_range(0, 5));
      automatic logic [31:0] d = $urandom;
      ref_tick = 4'($urandom);
      if ($urandom_range(0, 30) == 0) hw_gate_req = ~hw_gate_req;
      if (r < 6)       drive(1, 0, KEY);
      else if (r < 8)  drive(1, 0, 32'd0);
      else if (r < 10) drive(1, 0, d);
      else if (r < 14) drive(1, 3, 32'd1);
      else if (r < 18) drive(1, 1, {29'd0, 3'($urandom)});
      else if (r < 22) drive(1, 2, {22'd0, 2'($urandom), 4'd0, 4'($urandom)});
      else if (r < 26) drive(1, a, d);
      else             drive(0, a, d);
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule